// File: doc/BRIEF.md
# Bit-Serial Masked Adder/Subtractor

This block is a one-bit-wide arithmetic unit for a serial datapath. Two operand streams, A and B, arrive one bit per clock, least significant bit first, across a machine cycle of `DIGITS * DIGIT_BITS` bit times. A pulse on `cycleStart` marks bit time 0. A single carry flip-flop links each bit time to the next, so the unit can add, subtract, increment or decrement a field of any width that fits in the cycle.

A word-select gate chooses the bit times in which the arithmetic takes effect. Outside the gate the A bit is copied to the output unchanged, so the register that is written back keeps its other digits. Increment and decrement force an initial carry or borrow of one at the first selected bit time and ignore B. When the selected window closes, the final carry or borrow is kept on a flag that a branch unit can test. For example, a subtraction over the window sets the flag exactly when A < B.

Top module: `serial_masked_alu`

## Requirements
- R1: Outside the word-select window, `resBit` equals `aBit` in the same bit time. Bits are taken least significant first, and `cycleStart` recurs every `DIGITS*DIGIT_BITS` bit times.
- R2: With `opSel` = 0 (add), the window bits of the result are (A + B) modulo 2^w over the w selected bits, starting from a carry-in of 0.
- R3: With `opSel` = 1 (subtract), the window bits are (A − B) modulo 2^w. The borrow chain uses next borrow = (B & bw) | (~A & (B | bw)), and the starting borrow is 0.
- R4: With `opSel` = 2 (increment), the window bits are (A + 1) modulo 2^w.
- R5: With `opSel` = 3 (decrement), the window bits are (A − 1) modulo 2^w.
- R6: `carryFlag` takes the final carry of an add or increment, or the final borrow of a subtract or decrement. The new value is visible from the second bit time after the last selected bit. It holds until the next window closes.
- R7: The forced initial carry or borrow is applied at the first selected bit time of the cycle, which may come after bit time 0. It is applied only once per cycle.
- R8: While `rstN` is low, `carryFlag` is 0 and `resBit` still follows `aBit` when no window is selected.
- R9: In increment and decrement the value of `bBit` has no effect on the result or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low reset |
| cycleStart | input | 1 | High during bit time 0 of each machine cycle |
| wordSel | input | 1 | High in the selected bit times (one contiguous window per cycle) |
| aBit | input | 1 | Serial A operand, LSB first |
| bBit | input | 1 | Serial B operand, LSB first |
| opSel | input | 2 | 0 add, 1 subtract, 2 increment, 3 decrement |
| resBit | output | 1 | Serial result bit |
| carryFlag | output | 1 | Final carry/borrow of the last closed window |

## Verification
The assertions assume three things about the inputs. `cycleStart` arrives with a fixed period of one machine cycle once the first cycle has begun. `wordSel` forms at most one contiguous run per cycle. `opSel` stays constant during a window. The stimulus builds every cycle with the same loop of exactly 56 bit times, with no gaps between cycles. Each window is set up as a single bit range [lo, hi] and the operation is held for the whole cycle, so all three assumptions hold throughout the run. After each operation the bench runs an idle cycle, which checks pass-through and the timing and holding of the flag.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_INC = 2'd2,
    OP_DEC = 2'd3
  } serOp_t;

  // Strobes passed from control to datapath for one bit time
  typedef struct packed {
    logic active;      // this bit time is inside the window
    logic useB;        // B operand takes part
    logic isSub;       // borrow chain instead of carry chain
    logic firstSel;    // first selected bit time of this cycle
    logic initOne;     // initial carry/borrow value is one
    logic latchFlag;   // window has just closed: capture carry
    logic clearCarry;  // start of cycle outside a window
  } serStrb_t;

endpackage

// File: rtl/serial_alu_ctrl.sv
module serial_alu_ctrl
  import serial_alu_pkg::*;
#(
  parameter int CYCLE_BITS = 56
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       wordSel,
  input  logic [1:0] opSel,
  output serStrb_t   strb
);

  localparam int CNT_W = $clog2(CYCLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYCLE_BITS);

  logic             seenQ;     // a selected bit has occurred this cycle
  logic             winQ;      // previous bit time was selected
  logic             startedQ;  // at least one cycle has begun
  logic [CNT_W-1:0] bitCnt;    // bit times since the last start
  logic             seenEff;
  serOp_t           op;

  assign op      = serOp_t'(opSel);
  assign seenEff = cycleStart ? 1'b0 : seenQ;

  always_comb begin
    strb            = '0;
    strb.active     = wordSel;
    strb.firstSel   = wordSel && !seenEff;
    strb.useB       = (op == OP_ADD) || (op == OP_SUB);
    strb.isSub      = (op == OP_SUB) || (op == OP_DEC);
    strb.initOne    = (op == OP_INC) || (op == OP_DEC);
    strb.latchFlag  = winQ && (!wordSel || cycleStart);
    strb.clearCarry = cycleStart && !wordSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ    <= 1'b0;
      winQ     <= 1'b0;
      startedQ <= 1'b0;
      bitCnt   <= '0;
    end else begin
      seenQ <= cycleStart ? wordSel : (seenQ | wordSel);
      winQ  <= wordSel;
      if (cycleStart) begin
        startedQ <= 1'b1;
        bitCnt   <= CNT_W'(1);
      end else if (bitCnt != CNT_MAX) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  // R1: the machine cycle has a fixed length once started
  p_cycle_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && startedQ) |-> (bitCnt == CNT_MAX));

  // R7: the forced initial carry is injected at most once per cycle
  p_first_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstSel |=> (!strb.firstSel || cycleStart));

endmodule

// File: rtl/serial_alu_dpath.sv
module serial_alu_dpath
  import serial_alu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     aBit,
  input  logic     bBit,
  input  serStrb_t strb,
  output logic     resBit,
  output logic     carryFlag
);

  logic carryQ;
  logic flagQ;
  logic opB;
  logic cin;
  logic aluBit;
  logic cout;

  assign opB    = strb.useB ? bBit : 1'b0;
  assign cin    = strb.firstSel ? strb.initOne : carryQ;
  assign aluBit = aBit ^ opB ^ cin;

  always_comb begin
    if (strb.isSub) cout = (opB & cin) | (~aBit & (opB | cin));
    else            cout = (aBit & opB) | (cin & (aBit | opB));
  end

  assign resBit    = strb.active ? aluBit : aBit;
  assign carryFlag = flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (strb.latchFlag)       flagQ  <= carryQ;
      if (strb.active)          carryQ <= cout;
      else if (strb.clearCarry) carryQ <= 1'b0;
    end
  end

  // R6: flag changes only when a window closes
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchFlag |=> $stable(carryFlag));

  // R2: carry state is frozen between windows
  p_carry_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active && !strb.clearCarry) |=> $stable(carryQ));

endmodule

// File: rtl/serial_masked_alu.sv
module serial_masked_alu
  import serial_alu_pkg::*;
#(
  parameter int DIGITS     = 14,
  parameter int DIGIT_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       wordSel,
  input  logic       aBit,
  input  logic       bBit,
  input  logic [1:0] opSel,
  output logic       resBit,
  output logic       carryFlag
);

  localparam int CYCLE_BITS = DIGITS * DIGIT_BITS;

  serStrb_t strb;

  serial_alu_ctrl #(.CYCLE_BITS(CYCLE_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .wordSel    (wordSel),
    .opSel      (opSel),
    .strb       (strb)
  );

  serial_alu_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .aBit      (aBit),
    .bBit      (bBit),
    .strb      (strb),
    .resBit    (resBit),
    .carryFlag (carryFlag)
  );

  // R1: unselected bit times pass A through
  p_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wordSel |-> (resBit == aBit));

endmodule

// File: tb/sim_serial_masked_alu.sv
module sim_serial_masked_alu;

  localparam int PERIOD = 10;
  localparam int W      = 56;
  localparam int NVEC   = 8;

  localparam logic [1:0] T_OP [NVEC] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
  localparam int         T_LO [NVEC] = '{0, 0, 0, 8, 16, 0, 4, 0};
  localparam int         T_HI [NVEC] = '{55, 55, 55, 23, 31, 55, 11, 55};
  localparam logic [W-1:0] T_A [NVEC] = '{
    56'h00000000001234, 56'hFFFFFFFFFFFFFF, 56'h00000000000005, 56'h123456789ABCDE,
    56'hFFFFFFFFFFFFFF, 56'h00000000000000, 56'h00000000000000, 56'h80000000000000};
  localparam logic [W-1:0] T_B [NVEC] = '{
    56'h00000000009999, 56'h00000000000001, 56'h00000000000009, 56'h00000000F0F0F0,
    56'h0F0F0F0F0F0F0F, 56'hFFFFFFFFFFFFFF, 56'hFFFFFFFFFFFFFF, 56'h00000000000005};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 1'b0;
  logic wordSel = 1'b0;
  logic aBit = 1'b0;
  logic bBit = 1'b0;
  logic [1:0] opSel = 2'd0;
  logic resBit;
  logic carryFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  serial_masked_alu u0 (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .wordSel(wordSel),
    .aBit(aBit), .bBit(bBit), .opSel(opSel), .resBit(resBit), .carryFlag(carryFlag)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Word-level reference, computed from the requirements
  task automatic model(input logic [1:0] op, input int lo, input int hi,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic f);
    int w;
    logic [63:0] m, aw, bw, s;
    w  = hi - lo + 1;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    aw = ({8'h0, a} >> lo) & m;
    bw = ({8'h0, b} >> lo) & m;
    case (op)
      2'd0: begin s = aw + bw;   f = s[w]; end
      2'd1: begin s = aw - bw;   f = (aw < bw); end
      2'd2: begin s = aw + 64'd1; f = (aw == m); end
      default: begin s = aw - 64'd1; f = (aw == 64'd0); end
    endcase
    r = W'(({8'h0, a} & ~(m << lo)) | ((s & m) << lo));
  endtask

  // One machine cycle; window [lo,hi], lo > hi means no window
  task automatic runCycle(input logic [1:0] op, input int lo, input int hi,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] got, output logic flagAt2,
                          output logic flagEnd);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      cycleStart = (i == 0);
      wordSel    = (i >= lo) && (i <= hi);
      aBit       = a[i];
      bBit       = b[i];
      opSel      = op;
      #1;
      got[i] = resBit;
      if (i == 2)     flagAt2 = carryFlag;
      if (i == W - 1) flagEnd = carryFlag;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got, exp, idleA;
    logic f2, fe, expF, f2b, feb;
    // R8: reset state
    aBit = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R8 flag in reset", W'(carryFlag), W'(0));
    check("R8 pass-through in reset", W'(resBit), W'(1));
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      model(T_OP[v], T_LO[v], T_HI[v], T_A[v], T_B[v], exp, expF);
      runCycle(T_OP[v], T_LO[v], T_HI[v], T_A[v], T_B[v], got, f2, fe);
      // R2 R3 R4 R5 R7 R9 by op; R1 for unselected bits
      case (T_OP[v])
        2'd0: check($sformatf("R2 add vec %0d", v), got, exp);
        2'd1: check($sformatf("R3 sub vec %0d", v), got, exp);
        2'd2: check($sformatf("R4 R7 R9 inc vec %0d", v), got, exp);
        default: check($sformatf("R5 R7 R9 dec vec %0d", v), got, exp);
      endcase
      idleA = T_A[v] ^ 56'h5A5A5A5A5A5A5A;
      runCycle(2'd0, 1, 0, idleA, T_B[v], got, f2b, feb);
      check($sformatf("R1 idle pass vec %0d", v), got, idleA);
      check($sformatf("R6 flag vec %0d", v), W'(f2b), W'(expF));
      check($sformatf("R6 flag hold vec %0d", v), W'(feb), W'(expF));
    end

    // R9: same increment with a different B gives the same outcome
    runCycle(2'd2, 16, 31, 56'h00000000FFFF00, 56'h0, got, f2, fe);
    model(2'd2, 16, 31, 56'h00000000FFFF00, 56'hFFFFFFFFFFFFFF, exp, expF);
    check("R9 inc ignores B", got, exp);
    runCycle(2'd0, 1, 0, 56'h0, 56'h0, got, f2b, feb);
    check("R9 inc flag ignores B", W'(f2b), W'(expF));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule